// File: doc/BRIEF.md
# Multiplexed sample input selector and formatter

This block conditions the sample stream for one channel of a digital downconverter before it reaches the mixer. Each clock it takes a 16-bit word from one of four parallel sample buses, or from a test word loaded by a processor write. It qualifies that word with the enable of the chosen source and converts it to a 16-bit two's-complement word. It can also pull one channel out of a time-multiplexed stream of up to eight channels.

The sample enable runs in one of two ways. In gated mode, each enabled clock yields exactly one output pulse, and the clocks in between stall. In interpolated mode, the output is valid every clock and carries zero wherever no sample was enabled. This raises the input rate to the clock rate by inserting zeros. A single control word selects the source, the enable mode, the channel delay and the number format. After reset all enables are blocked until the first sync pulse.

The output has no ready input and cannot be back-pressured. In interpolated mode the consumer must accept a word every clock. In gated mode it must accept a word on every clock where `out_valid` is high.

Top module: `mux_sample_conditioner`

## Requirements
- R1: Control bit 1 set selects the test word as the source, and `test_strobe` is its enable. With bit 1 clear, bits [3:2] pick bus 0..3 from lane `bus_data[16*n+15:16*n]`, and the enables and data of the buses that are not selected have no effect. `test_wr` loads `test_wdata` into the test word at the clock edge.
- R2: Each bus enable `bus_en_n[n]` is active low at the pin.
- R3: In gated mode (control bit 0 clear), an enable present in clock k gives `out_valid` high for exactly one clock, in clock k+3. In clocks without such an enable, `out_valid` is low and `out_data` holds its value.
- R4: In interpolated mode (control bit 0 set), `out_valid` is high every clock. `out_data` is the converted sample in clock k+3 after an enable in clock k, and zero in every other clock.
- R5: After reset, all enables are ignored until a `sync_in` pulse has been seen. The enables then stay released until the next reset.
- R6: Let D be the channel delay in control bits [6:4]. For an enable in clock k, the converted word is the sample presented in clock p+D, where p is the latest earlier enable clock with p+D < k. If there is no such clock, the word is zero. With one-clock enables every 8 clocks that line up with channel 0, the output is channel D.
- R7: In fixed-point mode (control bit 7 clear), control bit 10 set marks the input as offset binary and inverts bit 15. With bit 10 clear, the word passes unchanged. Bit 10 is ignored in floating-point mode.
- R8: In floating-point mode (control bit 7 set), control bits [9:8] give the mantissa/exponent split. The codes 0, 1, 2 and 3 give 11/3, 12/3, 13/3 and 14/2. The exponent is in the low bits and the two's-complement mantissa sits directly above it; unused upper bits are ignored. The result is the mantissa times 2 to the power of the exponent.
- R9: A floating-point result above 32767 gives 16'h7FFF, and one below -32768 gives 16'h8000.
- R10: Reset clears the control word to 0, which means gated mode, bus 0, delay 0, fixed two's complement. During reset `out_valid` and `out_data` are 0. `ctl_wr` loads `ctl_wdata`, and the new value takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 64 | Four 16-bit sample buses; bus n is in bits [16n+15:16n] |
| bus_en_n | input | 4 | Per-bus sample enable, active low |
| sync_in | input | 1 | Releases the sample enables |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 11 | Control word value |
| test_wr | input | 1 | Test word write strobe |
| test_wdata | input | 16 | Test word value |
| test_strobe | input | 1 | One-clock enable for the test word |
| out_data | output | 16 | Two's-complement sample to the mixer |
| out_valid | output | 1 | Sample qualifier |

## Verification
The assertions assume that the control word does not change while samples are in flight. This matters because the gated-mode checks relate `out_valid` to the enable seen three clocks earlier, with the mode sampled in between. The stimulus writes the control word only right after reset and before the sync pulse, then keeps it fixed for a whole run. Every run starts from reset, so the capture and realign registers begin at zero. This is what lets the bench apply the rule for the case where no earlier enable exists.

// File: rtl/infmt_pkg.sv
package infmt_pkg;
  localparam int SMP_W  = 16;
  localparam int N_BUS  = 4;
  localparam int DLY_W  = 3;
  localparam int SEL_W  = $clog2(N_BUS);

  typedef struct packed {
    logic             offset_bin;
    logic [1:0]       flt_fmt;
    logic             use_float;
    logic [DLY_W-1:0] tdm_dly;
    logic [SEL_W-1:0] bus_sel;
    logic             use_test;
    logic             interp;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/infmt_src_sel.sv
module infmt_src_sel #(
  parameter int W  = 16,
  parameter int NB = 4,
  localparam int SW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB*W-1:0] bus_data,
  input  logic [NB-1:0] bus_en_n,
  input  logic [W-1:0]  test_word,
  input  logic          test_strobe,
  input  logic          use_test,
  input  logic [SW-1:0] bus_sel,
  input  logic          armed,
  output logic          sel_en,
  output logic [W-1:0]  in_d,
  output logic          in_en
);
  logic [W-1:0] lane [NB];
  logic [W-1:0] pick_d;
  logic         pick_en;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = bus_data[g*W +: W];
  end

  always_comb begin
    pick_d  = lane[bus_sel];
    pick_en = ~bus_en_n[bus_sel];
    if (use_test) begin
      pick_d  = test_word;
      pick_en = test_strobe;
    end
  end

  assign sel_en = pick_en & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_d  <= '0;
      in_en <= 1'b0;
    end else begin
      in_d  <= pick_d;
      in_en <= sel_en;
    end
  end
endmodule

// File: rtl/infmt_tdm_pick.sv
module infmt_tdm_pick #(
  parameter int W  = 16,
  parameter int DW = 3,
  localparam int DEPTH = 1 << DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  in_d,
  input  logic          in_en,
  input  logic [DW-1:0] dly,
  output logic [W-1:0]  al_d,
  output logic          al_fire
);
  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:1] tail;
  logic [W-1:0]     cap;

  assign hist = {tail, in_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail    <= '0;
      cap     <= '0;
      al_d    <= '0;
      al_fire <= 1'b0;
    end else begin
      tail    <= hist[DEPTH-2:0];
      al_fire <= in_en;
      if (hist[dly]) cap  <= in_d;
      if (in_en)     al_d <= cap;
    end
  end
endmodule

// File: rtl/infmt_conv.sv
module infmt_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] al_d,
  input  logic        al_fire,
  input  logic        interp,
  input  logic        use_float,
  input  logic [1:0]  flt_fmt,
  input  logic        offset_bin,
  output logic [15:0] out_data,
  output logic        out_valid
);
  logic [1:0]         e_w;
  logic [4:0]         m_w;
  logic [4:0]         sh;
  logic [2:0]         ex;
  logic [15:0]        mraw;
  logic [15:0]        tpos;
  logic signed [15:0] mant;
  logic signed [31:0] ext;
  logic signed [31:0] wide;
  logic [15:0]        flt_res;
  logic [15:0]        fix_res;
  logic [15:0]        conv;

  always_comb begin
    e_w  = (flt_fmt == 2'd3) ? 2'd2 : 2'd3;
    m_w  = (flt_fmt == 2'd3) ? 5'd14 : (5'd11 + {3'd0, flt_fmt});
    sh   = 5'd16 - m_w;
    ex   = (e_w == 2'd2) ? {1'b0, al_d[1:0]} : al_d[2:0];
    mraw = al_d >> e_w;
    tpos = mraw << sh;
    mant = $signed(tpos) >>> sh;
    ext  = {{16{mant[15]}}, mant};
    wide = ext <<< ex;
    if (wide > 32'sd32767)       flt_res = 16'h7FFF;
    else if (wide < -32'sd32768) flt_res = 16'h8000;
    else                         flt_res = wide[15:0];
    fix_res = offset_bin ? {~al_d[15], al_d[14:0]} : al_d;
    conv    = use_float ? flt_res : fix_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= interp | al_fire;
      if (al_fire)     out_data <= conv;
      else if (interp) out_data <= '0;
    end
  end
endmodule

// File: rtl/mux_sample_conditioner.sv
module mux_sample_conditioner
  import infmt_pkg::*;
#(
  parameter int NBUS = N_BUS,
  localparam int BUS_W = NBUS * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic [NBUS-1:0]  bus_en_n,
  input  logic             sync_in,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             test_wr,
  input  logic [SMP_W-1:0] test_wdata,
  input  logic             test_strobe,
  output logic [SMP_W-1:0] out_data,
  output logic             out_valid
);
  ctl_t             ctl_q;
  logic [SMP_W-1:0] test_word;
  logic             armed;
  logic             sel_en;
  logic [SMP_W-1:0] in_d;
  logic             in_en;
  logic [SMP_W-1:0] al_d;
  logic             al_fire;
  logic             ctl_interp;

  assign ctl_interp = ctl_q.interp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      test_word <= '0;
      armed     <= 1'b0;
    end else begin
      if (ctl_wr)  ctl_q     <= ctl_t'(ctl_wdata);
      if (test_wr) test_word <= test_wdata;
      if (sync_in) armed     <= 1'b1;
    end
  end

  infmt_src_sel #(.W(SMP_W), .NB(NBUS)) src_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_en_n(bus_en_n),
    .test_word(test_word), .test_strobe(test_strobe),
    .use_test(ctl_q.use_test), .bus_sel(ctl_q.bus_sel), .armed(armed),
    .sel_en(sel_en), .in_d(in_d), .in_en(in_en)
  );

  infmt_tdm_pick #(.W(SMP_W), .DW(DLY_W)) tdm_i (
    .clk(clk), .rst_n(rst_n), .in_d(in_d), .in_en(in_en),
    .dly(ctl_q.tdm_dly), .al_d(al_d), .al_fire(al_fire)
  );

  infmt_conv conv_i (
    .clk(clk), .rst_n(rst_n), .al_d(al_d), .al_fire(al_fire),
    .interp(ctl_interp), .use_float(ctl_q.use_float),
    .flt_fmt(ctl_q.flt_fmt), .offset_bin(ctl_q.offset_bin),
    .out_data(out_data), .out_valid(out_valid)
  );
endmodule

// File: rtl/infmt_checks.sv
module infmt_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        interp,
  input logic        armed,
  input logic        sel_en,
  input logic        al_fire,
  input logic        out_valid,
  input logic [15:0] out_data
);
  // R4
  interp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(interp) |-> out_valid);

  // R3
  gated_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(interp) && out_valid) |-> $past(sel_en, 3));

  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(interp) && !out_valid) |-> $stable(out_data));

  // R4
  interp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(interp) && !$past(al_fire)) |-> (out_data == 16'h0000));

  // R5
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

bind mux_sample_conditioner infmt_checks chk_i (
  .clk(clk), .rst_n(rst_n), .interp(ctl_interp), .armed(armed),
  .sel_en(sel_en), .al_fire(al_fire), .out_valid(out_valid),
  .out_data(out_data)
);

// File: tb/mux_sample_conditioner_tb_top.sv
`timescale 1ns/1ps
module mux_sample_conditioner_tb_top;
  localparam int RUN = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] bus_data;
  logic [3:0]  bus_en_n;
  logic        sync_in, ctl_wr, test_wr, test_strobe;
  logic [10:0] ctl_wdata;
  logic [15:0] test_wdata;
  logic [15:0] out_data;
  logic        out_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] rec_d [RUN];
  bit          rec_en [RUN];
  logic [15:0] sat_word [4] = '{16'h7FFF, 16'h8003, 16'h3FFF, 16'hC003};

  always #2.5 clk = ~clk;

  mux_sample_conditioner dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_en_n(bus_en_n),
    .sync_in(sync_in), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .test_wr(test_wr), .test_wdata(test_wdata), .test_strobe(test_strobe),
    .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmt_exp(input logic [15:0] w, input bit flt,
                                          input int ff, input bit ofs);
    int wi, eb, mb, ex, m;
    longint v;
    if (!flt) return ofs ? (w ^ 16'h8000) : w;
    wi = int'(w);
    eb = (ff == 3) ? 2 : 3;
    mb = (ff == 3) ? 14 : 11 + ff;
    ex = wi % (1 << eb);
    m  = (wi >> eb) % (1 << mb);
    if (m >= (1 << (mb - 1))) m -= (1 << mb);
    v = longint'(m) * (longint'(1) << ex);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  function automatic logic [10:0] mk(input bit ip, input bit tst, input int sel,
                                     input int dly, input bit flt, input int ff, input bit ofs);
    return {ofs, 2'(ff), flt, 3'(dly), 2'(sel), tst, ip};
  endfunction

  task automatic idle();
    bus_data = '0; bus_en_n = '1; sync_in = 0; ctl_wr = 0; ctl_wdata = '0;
    test_wr = 0; test_wdata = '0; test_strobe = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    idle(); rst_n = 0;
    @(negedge clk);
    check(out_valid == 0 && out_data == 0, "R10 reset state", {out_valid, out_data}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic run(input logic [10:0] ctl, input int pat, input bit satd,
                     input bit nowr, input string req);
    bit ip, tst, flt, ofs, en_c, vexp;
    int sel, dly, ff, k;
    logic [15:0] treg_m, exp_out, src;
    ip = ctl[0]; tst = ctl[1]; sel = int'(ctl[3:2]); dly = int'(ctl[6:4]);
    flt = ctl[7]; ff = int'(ctl[9:8]); ofs = ctl[10];
    treg_m = '0; exp_out = '0;
    do_reset();
    if (!nowr) begin
      @(posedge clk); #1 ctl_wr = 1; ctl_wdata = ctl;
    end
    @(posedge clk); #1 ctl_wr = 0; sync_in = 1;
    for (int c = 0; c < RUN; c++) begin
      @(posedge clk); #1;
      sync_in = 0;
      case (pat)
        0:       en_c = 1;
        1:       en_c = (c % 8 == 0);
        default: en_c = ($urandom % 3 == 0);
      endcase
      for (int b = 0; b < 4; b++) bus_data[b*16 +: 16] = 16'($urandom);
      bus_en_n = 4'($urandom);
      if (satd) bus_data[sel*16 +: 16] = sat_word[c % 4];
      test_wr = tst && (c % 2 == 0);
      test_wdata = 16'($urandom);
      test_strobe = 0;
      if (tst) begin
        test_strobe = en_c;
        rec_d[c] = treg_m;
      end else begin
        bus_en_n[sel] = ~en_c;
        rec_d[c] = bus_data[sel*16 +: 16];
      end
      rec_en[c] = en_c;
      if (test_wr) treg_m = test_wdata;
      @(negedge clk);
      if (c >= 3 && rec_en[c-3]) begin
        k = c - 3; src = '0;
        for (int p = k - 1; p >= 0; p--)
          if (rec_en[p] && p + dly < k) begin src = rec_d[p + dly]; break; end
        exp_out = fmt_exp(src, flt, ff, ofs);
        vexp = 1;
      end else begin
        vexp = ip;
        if (ip) exp_out = '0;
      end
      check(out_valid == vexp, {req, " valid"}, out_valid, vexp);
      check(out_data == exp_out, {req, " data"}, out_data, exp_out);
    end
    @(posedge clk); #1 idle();
  endtask

  initial begin
    rst_n = 0; idle();
    // R10: control word reset value gives plain bus 0 passthrough
    run('0, 0, 0, 1, "R10 default");
    // R5: enables blocked until sync
    do_reset();
    for (int c = 0; c < 16; c++) begin
      @(posedge clk); #1 bus_en_n = 4'b0000; bus_data = {4{16'($urandom)}};
      @(negedge clk);
      check(out_valid == 0, "R5 no sync", out_valid, 0);
    end
    @(posedge clk); #1 sync_in = 1;
    @(posedge clk); #1 sync_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1, "R5 after sync", out_valid, 1);
    // R1 R2: every bus, continuous and sparse
    for (int s = 0; s < 4; s++) begin
      run(mk(0, 0, s, 0, 0, 0, 0), 0, 0, 0, "R1 R2 bus");
      run(mk(0, 0, s, 0, 0, 0, 0), 2, 0, 0, "R1 R3 sparse");
    end
    // R1: test word source
    run(mk(0, 1, 2, 0, 0, 0, 0), 2, 0, 0, "R1 test gated");
    run(mk(1, 1, 0, 0, 0, 0, 0), 2, 0, 0, "R1 R4 test interp");
    // R6: all channel delays with frame pulses
    for (int d = 0; d < 8; d++) run(mk(0, 0, 1, d, 0, 0, 0), 1, 0, 0, "R6 tdm");
    run(mk(0, 0, 3, 5, 0, 0, 0), 2, 0, 0, "R6 tdm sparse");
    // R4: interpolated mode
    run(mk(1, 0, 0, 0, 0, 0, 0), 2, 0, 0, "R4 interp");
    run(mk(1, 0, 2, 3, 0, 0, 0), 1, 0, 0, "R4 R6 interp tdm");
    // R7: offset binary
    run(mk(0, 0, 1, 0, 0, 0, 1), 0, 0, 0, "R7 offset");
    // R8: every float format, offset bit ignored
    for (int f = 0; f < 4; f++) begin
      run(mk(0, 0, f, 0, 1, f, 0), 0, 0, 0, "R8 float");
      run(mk(0, 0, 0, 0, 1, f, 1), 2, 0, 0, "R7 R8 float ofs");
    end
    // R9: saturation corners
    run(mk(0, 0, 2, 0, 1, 3, 0), 0, 1, 0, "R9 sat 14/2");
    run(mk(0, 0, 1, 0, 1, 0, 0), 0, 1, 0, "R9 sat 11/3");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule